// File: doc/BRIEF.md
# Tone-Gated Satellite Control Encoder

This block turns a short control message for outdoor satellite equipment into a timed on/off pattern on one line. A high level on that line means a 22 kHz carrier is present and a low level means the line is quiet. Each bit is pulse-width coded with a fixed total length of three short units. A logic 1 is a short high followed by a long low. A logic 0 is a long high followed by a short low. Every byte goes out most significant bit first and is followed by one parity bit that makes the number of ones odd. A quiet guard gap comes before the first byte and after the last one. The sequence may end with one of two burst forms: a tone burst, which is a single long high pulse, or a data burst, which is the byte 0xFF with its parity bit. After either burst the line stays quiet for a hold period.

Message bytes are written through a ready/valid load port while the block is idle. The burst choice is sampled together with a start pulse. While no sequence is running, the line follows a continuous-tone enable input. Once started, the sequencer owns the line until it issues a one-cycle done pulse. All timing comes from a microsecond tick that a parameterised divider derives from the system clock. When the `GEN_CARRIER` parameter is set, the block ANDs the gate with an internal carrier. When it is clear, the block drives the raw gate.

The sequencer has seven states. It leaves IDLE on start and enters LEAD, the leading guard gap. From LEAD it goes to MARK if bytes are stored, otherwise to TRAIL. MARK is the high part of a bit and always goes to SPACE, the low part. SPACE goes to MARK for the next bit or byte. After the last parity bit, SPACE goes to TRAIL, or to HOLD when the bits belonged to a data burst. From TRAIL, a tone burst leads to TONE, a data burst leads to MARK with the burst flag set, and no burst leads to IDLE with done. TONE goes to HOLD. HOLD goes to IDLE with done.

Top module: `sat_tone_encoder`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, ld_ready_o=1, and line_o follows tone_en_i.
- R2: While busy_o=0, line_o equals tone_en_i. While busy_o=1, tone_en_i has no effect on line_o.
- R3: While idle, each cycle with ld_valid_i=1 and ld_ready_o=1 stores ld_data_i as the next message byte. ld_ready_o drops once MAX_BYTES bytes are held, and a byte offered while ld_ready_o=0 is not stored.
- R4: A start_i pulse while idle raises busy_o at the next clock edge. The line then stays low for GAP_US microseconds.
- R5: A data bit of value 1 is sent as SHORT_US high, then LONG_US low.
- R6: A data bit of value 0 is sent as LONG_US high, then SHORT_US low.
- R7: Bytes are sent in load order, each starting with bit 7.
- R8: After every byte, one parity bit is sent with the same bit coding. Its value is 1 XOR the eight data bits.
- R9: After the last byte the line stays low for GAP_US. With zero stored bytes, the two gaps run back to back as 2×GAP_US low.
- R10: When burst_sel_i=2'b01 at start (tone burst), the trailing gap is followed by TONE_US high and then HOLD_US low.
- R11: When burst_sel_i=2'b10 at start (data burst), the trailing gap is followed by 0xFF and parity bit 1, all as 1-bits, and then HOLD_US low.
- R12: With burst_sel_i=2'b00 or 2'b11, the sequence ends immediately after the trailing gap, with no hold period.
- R13: start_i while busy_o=1 has no effect, and ld_ready_o stays 0 while busy, so no byte is stored.
- R14: The sequence ends with done_o high for exactly one cycle, in the same cycle busy_o falls. The stored message is then emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_en_i | input | 1 | Continuous-tone request, used while idle |
| ld_valid_i | input | 1 | Message byte offered |
| ld_data_i | input | 8 | Message byte |
| ld_ready_o | output | 1 | Byte can be accepted (idle and not full) |
| burst_sel_i | input | 2 | 00/11 none, 01 tone burst, 10 data burst; sampled with start |
| start_i | input | 1 | Launch the sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| line_o | output | 1 | Carrier gate, or gated carrier when GEN_CARRIER=1 |

## Verification
Every segment starts on the clock edge where the previous one ends. Each segment lasts exactly its microsecond count times CLK_PER_US cycles, because the tick divider restarts at every segment boundary. busy_o rises one edge after start_i is sampled. done_o and the fall of busy_o appear together, one edge after the last segment ends. The bench samples at falling edges and measures run lengths of equal line levels while busy. It compares each run against a queue of merged expected segments, which are computed from the loaded bytes and the burst choice before start. Because the lengths are compared exactly in cycles, any off-by-one in a state's duration is caught.

// File: rtl/sat_tone_pkg.sv
package sat_tone_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_MARK,
        ST_SPACE,
        ST_TRAIL,
        ST_TONE,
        ST_HOLD
    } seq_state_e;

    localparam logic [1:0] BURST_NONE = 2'b00;
    localparam logic [1:0] BURST_TONE = 2'b01;
    localparam logic [1:0] BURST_DATA = 2'b10;

    localparam logic [3:0] PAR_POS    = 4'd8;
    localparam logic [7:0] DATA_BURST = 8'hFF;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sat_us_tick.sv
module sat_us_tick #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(CLK_PER_US - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sat_seg_timer.sv
module sat_seg_timer #(
    parameter int UW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [UW-1:0] load_us,
    input  logic          tick,
    output logic          expire
);
    logic [UW-1:0] remain_q;

    assign expire = tick && (remain_q == UW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_us;
        end else if (tick && (remain_q != '0)) begin
            remain_q <= remain_q - 1'b1;
        end
    end
endmodule

// File: rtl/sat_msg_store.sv
module sat_msg_store #(
    parameter int MAX_BYTES = 4,
    localparam int IW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int CW = $clog2(MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx_a,
    output logic [7:0]    rd_data_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [7:0]    rd_data_b,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [7:0]    mem_q [MAX_BYTES];
    logic [CW-1:0] cnt_q;

    assign count = cnt_q;
    assign full  = (cnt_q == CW'(MAX_BYTES));

    assign rd_data_a = (32'(rd_idx_a) < MAX_BYTES) ? mem_q[rd_idx_a] : 8'h00;
    assign rd_data_b = (32'(rd_idx_b) < MAX_BYTES) ? mem_q[rd_idx_b] : 8'h00;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < MAX_BYTES; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else if (wr_en && !full) begin
            mem_q[cnt_q[IW-1:0]] <= wr_data;
            cnt_q                <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sat_carrier.sv
module sat_carrier #(
    parameter int HALF_CLKS = 2272
) (
    input  logic clk,
    input  logic rst_n,
    output logic carrier
);
    localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [HW-1:0] cnt_q;
    logic          car_q;

    assign carrier = car_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            car_q <= 1'b0;
        end else if (cnt_q == HW'(HALF_CLKS - 1)) begin
            cnt_q <= '0;
            car_q <= ~car_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sat_tone_encoder.sv
module sat_tone_encoder
    import sat_tone_pkg::*;
#(
    parameter int CLK_PER_US  = 100,
    parameter int MAX_BYTES   = 4,
    parameter int SHORT_US    = 500,
    parameter int LONG_US     = 1000,
    parameter int GAP_US      = 16000,
    parameter int TONE_US     = 12500,
    parameter int HOLD_US     = 20000,
    parameter int GEN_CARRIER = 0,
    parameter int CARRIER_HZ  = 22000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_en_i,
    input  logic       ld_valid_i,
    input  logic [7:0] ld_data_i,
    output logic       ld_ready_o,
    input  logic [1:0] burst_sel_i,
    input  logic       start_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       line_o
);
    localparam int MAX_US = max_i(max_i(max_i(SHORT_US, LONG_US), max_i(GAP_US, TONE_US)), HOLD_US);
    localparam int UW     = $clog2(MAX_US + 1);
    localparam int IW     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int CW     = $clog2(MAX_BYTES + 1);
    localparam int HALF_RAW  = (CLK_PER_US * 1000000) / (2 * CARRIER_HZ);
    localparam int HALF_CLKS = (HALF_RAW > 0) ? HALF_RAW : 1;

    seq_state_e    state_q, state_d;
    logic [IW-1:0] byte_q, byte_d;
    logic [3:0]    bit_q, bit_d;
    logic          par_q, par_d;
    logic          bb_q, bb_d;
    logic [1:0]    burst_q, burst_d;
    logic          done_q, done_d;

    logic          tick, expire, seg_load;
    logic [UW-1:0] seg_us;
    logic [7:0]    store_a, store_b;
    logic [CW-1:0] msg_cnt;
    logic          msg_full;
    logic [7:0]    cur_byte, nxt_byte;
    logic          cur_bit, nxt_bit;
    logic          seq_gate;
    logic          busy;

    // ---------------- submodules ----------------
    sat_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (seg_load),
        .tick  (tick)
    );

    sat_seg_timer #(.UW(UW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seg_load),
        .load_us (seg_us),
        .tick    (tick),
        .expire  (expire)
    );

    sat_msg_store #(.MAX_BYTES(MAX_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_valid_i && ld_ready_o),
        .wr_data   (ld_data_i),
        .clr       (done_d),
        .rd_idx_a  (byte_q),
        .rd_data_a (store_a),
        .rd_idx_b  (byte_d),
        .rd_data_b (store_b),
        .count     (msg_cnt),
        .full      (msg_full)
    );

    // ---------------- bit selection ----------------
    assign cur_byte = bb_q ? DATA_BURST : store_a;
    assign nxt_byte = bb_d ? DATA_BURST : store_b;
    assign cur_bit  = (bit_q == PAR_POS) ? par_q : cur_byte[3'd7 - bit_q[2:0]];
    assign nxt_bit  = (bit_d == PAR_POS) ? par_d : nxt_byte[3'd7 - bit_d[2:0]];

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            bit_q   <= '0;
            par_q   <= 1'b1;
            bb_q    <= 1'b0;
            burst_q <= BURST_NONE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            bit_q   <= bit_d;
            par_q   <= par_d;
            bb_q    <= bb_d;
            burst_q <= burst_d;
            done_q  <= done_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        bit_d   = bit_q;
        par_d   = par_q;
        bb_d    = bb_q;
        burst_d = burst_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_LEAD;
                    burst_d = burst_sel_i;
                    byte_d  = '0;
                    bit_d   = '0;
                    par_d   = 1'b1;
                    bb_d    = 1'b0;
                end
            end
            ST_LEAD: begin
                if (expire) begin
                    state_d = (msg_cnt != '0) ? ST_MARK : ST_TRAIL;
                end
            end
            ST_MARK: begin
                if (expire) begin
                    state_d = ST_SPACE;
                end
            end
            ST_SPACE: begin
                if (expire) begin
                    if (bit_q == PAR_POS) begin
                        bit_d = '0;
                        par_d = 1'b1;
                        if (bb_q) begin
                            state_d = ST_HOLD;
                        end else if ((CW'(byte_q) + CW'(1)) == msg_cnt) begin
                            state_d = ST_TRAIL;
                        end else begin
                            byte_d  = byte_q + 1'b1;
                            state_d = ST_MARK;
                        end
                    end else begin
                        bit_d   = bit_q + 1'b1;
                        par_d   = par_q ^ cur_bit;
                        state_d = ST_MARK;
                    end
                end
            end
            ST_TRAIL: begin
                if (expire) begin
                    if (burst_q == BURST_TONE) begin
                        state_d = ST_TONE;
                    end else if (burst_q == BURST_DATA) begin
                        state_d = ST_MARK;
                        bb_d    = 1'b1;
                        bit_d   = '0;
                        par_d   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end
                end
            end
            ST_TONE: begin
                if (expire) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (expire) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- segment length ----------------
    assign seg_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_LEAD, ST_TRAIL: seg_us = UW'(GAP_US);
            ST_MARK:           seg_us = nxt_bit ? UW'(SHORT_US) : UW'(LONG_US);
            ST_SPACE:          seg_us = cur_bit ? UW'(LONG_US) : UW'(SHORT_US);
            ST_TONE:           seg_us = UW'(TONE_US);
            ST_HOLD:           seg_us = UW'(HOLD_US);
            default:           seg_us = '0;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state_q != ST_IDLE);
        ld_ready_o = !busy && !msg_full;
        seq_gate   = busy ? ((state_q == ST_MARK) || (state_q == ST_TONE)) : tone_en_i;
    end

    assign busy_o = busy;
    assign done_o = done_q;

    generate
        if (GEN_CARRIER != 0) begin : g_carrier
            logic carrier;
            sat_carrier #(.HALF_CLKS(HALF_CLKS)) u_carrier (
                .clk     (clk),
                .rst_n   (rst_n),
                .carrier (carrier)
            );
            assign line_o = seq_gate & carrier;
        end else begin : g_raw
            assign line_o = seq_gate;
        end
    endgenerate
endmodule

// File: rtl/sat_tone_encoder_chk.sv
module sat_tone_encoder_chk #(
    parameter int CLK_PER_US = 100,
    parameter int LONG_US    = 1000,
    parameter int TONE_US    = 12500
) (
    input logic clk,
    input logic rst_n,
    input logic ld_ready_o,
    input logic busy_o,
    input logic done_o,
    input logic seq_gate
);
    localparam int MAX_HIGH = ((LONG_US > TONE_US) ? LONG_US : TONE_US) * CLK_PER_US;
    localparam int HW       = $clog2(MAX_HIGH + 2);

    logic [HW-1:0] high_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !(busy_o && seq_gate)) begin
            high_run_q <= '0;
        end else if (high_run_q != {HW{1'b1}}) begin
            high_run_q <= high_run_q + 1'b1;
        end
    end

    a_r13_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !ld_ready_o);

    a_r14_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r14_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r14_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r4_lead_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !seq_gate);

    a_r10_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && seq_gate) |-> (32'(high_run_q) < MAX_HIGH));
endmodule

bind sat_tone_encoder sat_tone_encoder_chk #(
    .CLK_PER_US (CLK_PER_US),
    .LONG_US    (LONG_US),
    .TONE_US    (TONE_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_ready_o (ld_ready_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .seq_gate   (seq_gate)
);

// File: tb/sat_tone_encoder_tb.sv
`timescale 1ns/1ps
module sat_tone_encoder_tb;
    localparam int C  = 2;
    localparam int SH = 5;
    localparam int LG = 10;
    localparam int GP = 40;
    localparam int TN = 25;
    localparam int HD = 30;
    localparam int MB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_en_i = 1'b0;
    logic       ld_valid_i = 1'b0;
    logic [7:0] ld_data_i = 8'h00;
    logic [1:0] burst_sel_i = 2'b00;
    logic       start_i = 1'b0;
    logic       ld_ready_o, busy_o, done_o, line_o;

    always #5 clk = ~clk;

    sat_tone_encoder #(
        .CLK_PER_US(C), .MAX_BYTES(MB), .SHORT_US(SH), .LONG_US(LG),
        .GAP_US(GP), .TONE_US(TN), .HOLD_US(HD), .GEN_CARRIER(0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tone_en_i(tone_en_i),
        .ld_valid_i(ld_valid_i), .ld_data_i(ld_data_i), .ld_ready_o(ld_ready_o),
        .burst_sel_i(burst_sel_i), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .line_o(line_o)
    );

    typedef struct {
        logic  lvl;
        int    len;
        string tag;
    } seg_t;

    seg_t expq[$];
    int   n_checks = 0;
    int   n_err    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push_seg(input logic lvl, input int us, input string tag);
        if (expq.size() > 0 && expq[expq.size()-1].lvl == lvl)
            expq[expq.size()-1].len += us * C;
        else
            expq.push_back('{lvl, us * C, tag});
    endtask

    task automatic push_bit(input logic b, input string tag);
        if (b) begin
            push_seg(1'b1, SH, tag);
            push_seg(1'b0, LG, tag);
        end else begin
            push_seg(1'b1, LG, tag);
            push_seg(1'b0, SH, tag);
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        logic par;
        par = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            par = par ^ d[i];
            push_bit(d[i], d[i] ? "R5/R7" : "R6/R7");
        end
        push_bit(par, "R8");
    endtask

    task automatic load_byte(input logic [7:0] d, output bit acc);
        @(negedge clk);
        ld_valid_i = 1'b1;
        ld_data_i  = d;
        acc        = ld_ready_o;
        @(negedge clk);
        ld_valid_i = 1'b0;
    endtask

    // builds expectations for the accepted bytes and runs one sequence
    task automatic run_seq(input logic [7:0] msg[$], input logic [1:0] bsel,
                           input bit poke_busy, input string req);
        bit acc;
        push_seg(1'b0, GP, "R4");
        foreach (msg[i]) push_byte(msg[i]);
        push_seg(1'b0, GP, "R9");
        if (bsel == 2'b01) begin
            push_seg(1'b1, TN, "R10");
            push_seg(1'b0, HD, "R10");
        end else if (bsel == 2'b10) begin
            for (int i = 0; i < 9; i++) push_bit(1'b1, "R11");
            push_seg(1'b0, HD, "R11");
        end
        @(negedge clk);
        start_i     = 1'b1;
        burst_sel_i = bsel;
        @(negedge clk);
        start_i     = 1'b0;
        burst_sel_i = 2'b00;
        check(busy_o == 1'b1, "R4", "busy after start", busy_o, 1);
        if (poke_busy) begin
            repeat (30) @(negedge clk);
            load_byte(8'h5A, acc);
            check(acc == 1'b0, "R13", "ld_ready while busy", acc, 0);
            @(negedge clk);
            start_i     = 1'b1;
            burst_sel_i = 2'b01;
            @(negedge clk);
            start_i     = 1'b0;
            burst_sel_i = 2'b00;
        end
        do @(negedge clk); while (!done_o);
        @(negedge clk);
        check(done_o == 1'b0, "R14", "done one cycle", done_o, 0);
        check(expq.size() == 0, req, "segments left", expq.size(), 0);
        check(ld_ready_o == 1'b1, "R14", "ready after done", ld_ready_o, 1);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            check(busy_o == 1'b0, "R13", "no restart from busy start", busy_o, 0);
        end
    endtask

    // monitor: measures equal-level runs while busy and scores them
    task automatic close_run(input logic lvl, input int len);
        seg_t e;
        if (expq.size() == 0) begin
            check(1'b0, "R4", "unexpected segment", len, 0);
        end else begin
            e = expq.pop_front();
            check(lvl == e.lvl, e.tag, "segment level", lvl, e.lvl);
            check(len == e.len, e.tag, "segment length", len, e.len);
        end
    endtask

    initial begin
        logic cur;
        int   run;
        bit   prev_busy;
        cur = 1'b0;
        run = 0;
        prev_busy = 1'b0;
        forever begin
            @(negedge clk);
            if (busy_o) begin
                if (run == 0) begin
                    cur = line_o;
                    run = 1;
                end else if (line_o == cur) begin
                    run++;
                end else begin
                    close_run(cur, run);
                    cur = line_o;
                    run = 1;
                end
            end else if (prev_busy) begin
                close_run(cur, run);
                run = 0;
                check(done_o == 1'b1, "R14", "done as busy falls", done_o, 1);
            end
            prev_busy = busy_o;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] m[$];
        bit acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
        check(ld_ready_o == 1'b1, "R1", "ready after reset", ld_ready_o, 1);
        check(line_o == 1'b0, "R1", "line after reset", line_o, 0);
        // R2 idle passthrough
        tone_en_i = 1'b1;
        @(negedge clk);
        check(line_o == 1'b1, "R2", "idle tone on", line_o, 1);
        tone_en_i = 1'b0;
        @(negedge clk);
        check(line_o == 1'b0, "R2", "idle tone off", line_o, 0);

        // one byte, no burst (R5..R9, R12)
        load_byte(8'hA5, acc);
        check(acc == 1'b1, "R3", "byte accepted", acc, 1);
        m = '{8'hA5};
        run_seq(m, 2'b00, 1'b0, "R12");

        // two bytes, tone burst, tone_en high during sequence (R2, R7, R10)
        load_byte(8'h3C, acc);
        load_byte(8'h01, acc);
        tone_en_i = 1'b1;
        m = '{8'h3C, 8'h01};
        run_seq(m, 2'b01, 1'b0, "R10");
        @(negedge clk);
        check(line_o == 1'b1, "R2", "tone resumes when idle", line_o, 1);
        tone_en_i = 1'b0;

        // zero bytes, data burst (R9, R11)
        m = {};
        run_seq(m, 2'b10, 1'b0, "R11");

        // zero bytes, code 11 means no burst (R9, R12)
        run_seq(m, 2'b11, 1'b0, "R12");

        // full store, refused extra byte, pokes while busy (R3, R13)
        load_byte(8'h80, acc);
        load_byte(8'h00, acc);
        load_byte(8'hFE, acc);
        check(ld_ready_o == 1'b0, "R3", "ready low when full", ld_ready_o, 0);
        load_byte(8'h77, acc);
        check(acc == 1'b0, "R3", "extra byte refused", acc, 0);
        m = '{8'h80, 8'h00, 8'hFE};
        run_seq(m, 2'b10, 1'b1, "R3");

        // store emptied, busy-time byte not kept (R14, R13)
        load_byte(8'h81, acc);
        m = '{8'h81};
        run_seq(m, 2'b00, 1'b0, "R14");

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule